// File: doc/BRIEF.md
# I2C Status Flags and Arbitration Monitor

This block holds the status-flag logic of an I2C controller. It passes the SCL and SDA pins through a synchronizer and finds start and stop conditions on them. It also compares the SDA level that the controller drives with the level seen on the pin. Two sticky flags come out of this. The first is a stop-seen flag. The second is a shared flag that means arbitration loss in I2C format and receive overrun in clocked-synchronous format.

The stop flag is qualified by earlier bus activity. In master mode a stop counts only after a frame has completed. In slave mode a stop counts only after a start condition, a general call or a first-byte address match. Software reads the flags through a small read/write port. A flag clears only when a write of 0 follows a read that returned that flag as 1. When arbitration is lost, a one-cycle pulse tells the transmit logic to release SDA and leave master mode.

Top module: `i2c_flag_monitor`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` is 00, `arb_lost_pulse` is 0, and both stop-arming states are cleared. The synchronizer reset value is the idle bus level (high).
- R2: The pins go through a two-flop synchronizer. `start_det` pulses for one cycle when synchronized SDA falls while synchronized SCL is high. `stop_det` pulses when SDA rises while SCL is high. Either pulse appears in the cycle after the second clock edge that samples the pin change.
- R3: In master mode (`is_master`=1), a detected stop sets the stop flag (`reg_rdata` bit 0) if `frame_done` has pulsed since the previous stop.
- R4: A flag never sets without a setting event. In particular, a stop in master mode with no completed frame since the previous stop leaves the stop flag at 0.
- R5: In slave mode, a stop sets the stop flag only if a start, `gen_call_evt` or `addr_match_evt` has occurred since the previous stop.
- R6: A write (`reg_wr`) clears flag bit i only if `reg_wdata[i]`=0 and the most recent read of that bit, with no write in between, returned 1. A write of 0 without such a read, or a write of 1, leaves the flag unchanged. Any write to the port uses up the read qualification.
- R7: A setting event wins over a clearing write in the same cycle. A setting event that arrives between the read and the write keeps the flag set and cancels the read qualification.
- R8: In master transmit mode with I2C format (`sync_format`=0), a difference between `sda_drive` and synchronized SDA at a rising edge of synchronized SCL sets the shared flag (`reg_rdata` bit 1). It also raises `arb_lost_pulse` in the same cycle in which the flag first reads 1.
- R9: In master mode with I2C format, a start detected while `sda_drive`=1 sets the shared flag and pulses `arb_lost_pulse`.
- R10: In clocked-synchronous format, `last_bit_rx` together with `rx_full`=1 sets the shared flag as an overrun, without `arb_lost_pulse`. `last_bit_rx` with `rx_full`=0 sets nothing.
- R11: The SDA comparison sets nothing in receive mode or in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_pin | input | 1 | SCL pin level, asynchronous |
| sda_pin | input | 1 | SDA pin level, asynchronous |
| sda_drive | input | 1 | SDA level the controller drives (1 = released high) |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| is_transmit | input | 1 | 1 = transmit, 0 = receive |
| sync_format | input | 1 | 1 = clocked-synchronous format, 0 = I2C format |
| gen_call_evt | input | 1 | General call seen (slave), one-cycle strobe |
| addr_match_evt | input | 1 | First address byte matched (slave), one-cycle strobe |
| frame_done | input | 1 | Frame transfer complete, one-cycle strobe |
| last_bit_rx | input | 1 | Final bit of a byte received, one-cycle strobe |
| rx_full | input | 1 | Receive data register full |
| reg_rd | input | 1 | Status read strobe |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 2 | Write data: bit 0 stop, bit 1 arbitration/overrun |
| reg_rdata | output | 2 | Flags: bit 0 stop, bit 1 arbitration/overrun |
| start_det | output | 1 | Start condition pulse |
| stop_det | output | 1 | Stop condition pulse |
| arb_lost_pulse | output | 1 | One-cycle arbitration-lost pulse |

## Verification
The case that needs care is a software clear and a hardware set landing on the same flag in the same cycle. The bench reads the shared flag as 1 to qualify it. It then issues the write of 0 in the very cycle that an overrun strobe with `rx_full` high arrives, and in a second run it places the strobe between the read and the write. In both runs the flag must stay set, and a second read-then-write must be needed to clear it. A behavioural model in the bench checks the flags, the detection pulses and the arbitration pulse against the design on every clock.

// File: rtl/i2c_flag_pkg.sv
// Shared constants for the I2C status-flag monitor.
// Assumes: flag bit 0 is the stop flag and bit 1 is the arbitration/overrun flag.
package i2c_flag_pkg;
    localparam int FLAG_W    = 2;
    localparam int FLAG_STOP = 0;
    localparam int FLAG_ARB  = 1;
endpackage

// File: rtl/i2c_pin_sync.sv
// Multi-stage synchronizer for the bus pins.
// Assumes: the pins are asynchronous. Reset loads the idle bus level (all ones).
module i2c_pin_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin levels one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= '1;
                else if (g == 0) chain_q[g] <= pin_in;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
// Finds start and stop conditions and SCL rising edges on the synchronized pins.
// Assumes: the inputs are already synchronous to clk.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_c,
    output logic stop_c,
    output logic scl_rise
);
    logic scl_q, sda_q;

    // Keep the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise = scl_s & ~scl_q;
endmodule

// File: rtl/i2c_sticky_flag.sv
// One sticky status flag that software clears by reading it as 1 and then writing 0.
// Assumes: a setting event has priority over a clearing write, and any write uses up the read qualification.
module i2c_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    logic armed_q;

    // Update the flag and its read-as-1 qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_evt) begin
            flag    <= 1'b1;
            armed_q <= 1'b0;
        end else if (wr_en) begin
            if (!wr_bit && armed_q) flag <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_en) begin
            armed_q <= flag;
        end
    end

    // A flag falls only after a qualified write of 0.
    assert_clear_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(armed_q && wr_en && !wr_bit));

    // A setting event always leaves the flag set, whatever software writes.
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // A flag rises only after a setting event.
    assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_evt));
endmodule

// File: rtl/i2c_flag_monitor.sv
// Status-flag logic of an I2C controller: stop detection, arbitration loss and overrun.
// Assumes: the event strobes and sda_drive are synchronous to clk and the pins are asynchronous.
module i2c_flag_monitor
    import i2c_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_pin,
    input  logic              sda_pin,
    input  logic              sda_drive,
    input  logic              is_master,
    input  logic              is_transmit,
    input  logic              sync_format,
    input  logic              gen_call_evt,
    input  logic              addr_match_evt,
    input  logic              frame_done,
    input  logic              last_bit_rx,
    input  logic              rx_full,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    output logic              start_det,
    output logic              stop_det,
    output logic              arb_lost_pulse
);
    logic [1:0]        pins_s;
    logic              scl_s, sda_s, scl_rise;
    logic              mst_arm_q, slv_arm_q;
    logic              set_stop, set_arb_bus, set_ovr;
    logic [FLAG_W-1:0] set_vec;

    i2c_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in({scl_pin, sda_pin}), .pin_sync(pins_s));
    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2c_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .start_c(start_det), .stop_c(stop_det), .scl_rise(scl_rise));

    // Arm the stop flag from earlier bus events; every stop disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_arm_q <= 1'b0;
            slv_arm_q <= 1'b0;
        end else if (stop_det) begin
            mst_arm_q <= 1'b0;
            slv_arm_q <= 1'b0;
        end else begin
            if (frame_done) mst_arm_q <= 1'b1;
            if (start_det || gen_call_evt || addr_match_evt) slv_arm_q <= 1'b1;
        end
    end

    // Work out the setting events for each flag.
    always_comb begin
        set_stop    = stop_det && (is_master ? mst_arm_q : slv_arm_q);
        set_arb_bus = !sync_format && is_master &&
                      ((is_transmit && scl_rise && (sda_drive != sda_s)) ||
                       (start_det && sda_drive));
        set_ovr     = sync_format && last_bit_rx && rx_full;
        set_vec            = '0;
        set_vec[FLAG_STOP] = set_stop;
        set_vec[FLAG_ARB]  = set_arb_bus || set_ovr;
    end

    genvar f;
    generate
        for (f = 0; f < FLAG_W; f++) begin : g_flag
            i2c_sticky_flag u_flag (
                .clk(clk), .rst_n(rst_n), .set_evt(set_vec[f]),
                .rd_en(reg_rd), .wr_en(reg_wr), .wr_bit(reg_wdata[f]),
                .flag(reg_rdata[f]));
        end
    endgenerate

    // Register the one-cycle arbitration-lost pulse for the transmit logic.
    always_ff @(posedge clk) begin
        if (!rst_n) arb_lost_pulse <= 1'b0;
        else arb_lost_pulse <= set_arb_bus;
    end

    // The arbitration pulse comes with the shared flag set.
    assert_pulse_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_pulse |-> reg_rdata[FLAG_ARB]);

    // An overrun never raises the arbitration pulse.
    assert_no_pulse_on_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_pulse |-> !$past(sync_format));

    // A master stop that follows a completed frame sets the stop flag.
    assert_master_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && is_master && mst_arm_q) |=> reg_rdata[FLAG_STOP]);

    // Start and stop never appear together.
    assert_cond_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: tb/i2c_flag_monitor_bench.sv
module i2c_flag_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_pin = 1'b1, sda_pin = 1'b1, sda_drive = 1'b1;
    logic is_master = 1'b0, is_transmit = 1'b0, sync_format = 1'b0;
    logic gen_call_evt = 1'b0, addr_match_evt = 1'b0, frame_done = 1'b0;
    logic last_bit_rx = 1'b0, rx_full = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b00;
    logic [1:0] reg_rdata;
    logic start_det, stop_det, arb_lost_pulse;

    int total = 0, bad = 0, cyc_cnt = 0, pulse_cnt = 0, start_cnt = 0;
    string cur_req = "R1";
    bit check_on = 1'b0;

    // behavioural model state
    bit [2:0] scl_h = 3'b111, sda_h = 3'b111;
    bit m_stop, m_arb, a_stop, a_arb, m_marm, m_sarm, m_pulse;

    always #5 clk = ~clk;

    i2c_flag_monitor u_i2c_flag_monitor (
        .clk(clk), .rst_n(rst_n), .scl_pin(scl_pin), .sda_pin(sda_pin),
        .sda_drive(sda_drive), .is_master(is_master), .is_transmit(is_transmit),
        .sync_format(sync_format), .gen_call_evt(gen_call_evt),
        .addr_match_evt(addr_match_evt), .frame_done(frame_done),
        .last_bit_rx(last_bit_rx), .rx_full(rx_full), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_det(start_det), .stop_det(stop_det), .arb_lost_pulse(arb_lost_pulse));

    function automatic bit e_start(); return scl_h[1] & scl_h[2] & sda_h[2] & ~sda_h[1]; endfunction
    function automatic bit e_stop();  return scl_h[1] & scl_h[2] & ~sda_h[2] & sda_h[1]; endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        bit st, sp, rise, s_stop, s_bus, s_arb;
        if (!rst_n) begin
            scl_h = 3'b111; sda_h = 3'b111;
            m_stop = 0; m_arb = 0; a_stop = 0; a_arb = 0;
            m_marm = 0; m_sarm = 0; m_pulse = 0;
        end else begin
            st = e_start(); sp = e_stop(); rise = scl_h[1] & ~scl_h[2];
            s_stop = sp & (is_master ? m_marm : m_sarm);
            s_bus = !sync_format & is_master &
                    ((is_transmit & rise & (sda_drive != sda_h[1])) | (st & sda_drive));
            s_arb = s_bus | (sync_format & last_bit_rx & rx_full);
            if (s_stop) begin m_stop = 1; a_stop = 0; end
            else if (reg_wr) begin if (!reg_wdata[0] && a_stop) m_stop = 0; a_stop = 0; end
            else if (reg_rd) a_stop = m_stop;
            if (s_arb) begin m_arb = 1; a_arb = 0; end
            else if (reg_wr) begin if (!reg_wdata[1] && a_arb) m_arb = 0; a_arb = 0; end
            else if (reg_rd) a_arb = m_arb;
            if (sp) begin m_marm = 0; m_sarm = 0; end
            else begin
                if (frame_done) m_marm = 1;
                if (st | gen_call_evt | addr_match_evt) m_sarm = 1;
            end
            m_pulse = s_bus;
            scl_h = {scl_h[1:0], scl_pin};
            sda_h = {sda_h[1:0], sda_pin};
        end
    end

    // Compare the design with the model at every falling edge.
    always @(negedge clk) begin
        if (check_on) begin
            total++;
            if (reg_rdata !== {m_arb, m_stop} || arb_lost_pulse !== m_pulse ||
                start_det !== e_start() || stop_det !== e_stop()) begin
                bad++;
                $display("FAIL %s cycle %0d: got rdata=%b pulse=%b start=%b stop=%b exp rdata=%b pulse=%b start=%b stop=%b",
                         cur_req, cyc_cnt, reg_rdata, arb_lost_pulse, start_det, stop_det,
                         {m_arb, m_stop}, m_pulse, e_start(), e_stop());
            end
            if (arb_lost_pulse) pulse_cnt++;
            if (start_det) start_cnt++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d exp %0d", req, got, exp);
        end
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; cyc(1); s = 1'b0; cyc(1);
    endtask

    task automatic rd();
        reg_rd = 1; cyc(1); reg_rd = 0; cyc(1);
    endtask

    task automatic wr(input logic [1:0] d);
        reg_wdata = d; reg_wr = 1; cyc(1); reg_wr = 0; reg_wdata = 0; cyc(1);
    endtask

    task automatic bus_start();
        scl_pin = 1; sda_pin = 1; cyc(4);
        sda_pin = 0; cyc(5);
    endtask

    task automatic bus_stop();
        scl_pin = 0; cyc(4); sda_pin = 0; cyc(4);
        scl_pin = 1; cyc(4); sda_pin = 1; cyc(5);
    endtask

    initial begin
        cyc(4);
        rst_n = 1; cyc(1);
        check_on = 1;
        cyc(2);
        cur_req = "R1";
        chk("R1", reg_rdata, 0);
        chk("R1", arb_lost_pulse, 0);

        // R2 + R5: slave start arms, stop sets
        cur_req = "R2";
        bus_start();
        chk("R2", start_cnt, 1);
        cur_req = "R5";
        bus_stop();
        chk("R5", reg_rdata, 1);
        // R6: write 0 without read ignored, write 1 ignored
        cur_req = "R6";
        wr(2'b00); chk("R6", reg_rdata, 1);
        rd(); wr(2'b11); chk("R6", reg_rdata, 1);
        rd(); wr(2'b00); chk("R6", reg_rdata, 0);
        // R5: unarmed slave stop leaves flag clear; address match arms it
        cur_req = "R5";
        bus_stop(); chk("R5", reg_rdata, 0);
        strobe(addr_match_evt); bus_stop(); chk("R5", reg_rdata, 1);
        rd(); wr(2'b00);
        strobe(gen_call_evt); bus_stop(); chk("R5", reg_rdata, 1);
        rd(); wr(2'b00);

        // R3 / R4: master stop
        is_master = 1; sda_drive = 0;
        cur_req = "R4";
        bus_start(); bus_stop(); chk("R4", reg_rdata, 0);
        cur_req = "R3";
        bus_start(); strobe(frame_done); bus_stop(); chk("R3", reg_rdata, 1);
        rd(); wr(2'b10); chk("R3", reg_rdata, 0);

        // R8: master transmit mismatch at SCL rise
        cur_req = "R8";
        is_transmit = 1;
        scl_pin = 0; sda_pin = 0; sda_drive = 1; cyc(4);
        scl_pin = 1; cyc(5);
        chk("R8", reg_rdata, 2); chk("R8", pulse_cnt, 1);
        rd(); wr(2'b01); chk("R8", reg_rdata, 0);
        // matching level: no set
        scl_pin = 0; sda_drive = 0; cyc(4); scl_pin = 1; cyc(5);
        chk("R8", reg_rdata, 0);
        // R11: receive mode and slave mode ignore mismatches
        cur_req = "R11";
        is_transmit = 0; scl_pin = 0; sda_drive = 1; cyc(4); scl_pin = 1; cyc(5);
        chk("R11", reg_rdata, 0);
        is_transmit = 1; is_master = 0; scl_pin = 0; cyc(4); scl_pin = 1; cyc(5);
        chk("R11", reg_rdata, 0);
        chk("R11", pulse_cnt, 1);

        // R9: start while releasing SDA in master mode
        cur_req = "R9";
        is_master = 1; is_transmit = 0; sda_drive = 1;
        bus_start();
        chk("R9", reg_rdata, 2); chk("R9", pulse_cnt, 2);
        rd(); wr(2'b00);
        sda_drive = 0; bus_stop();
        rd(); wr(2'b00);
        chk("R9", reg_rdata, 0);

        // R10: overrun in clocked-synchronous format
        cur_req = "R10";
        is_master = 0; sync_format = 1;
        strobe(last_bit_rx); chk("R10", reg_rdata, 0);
        rx_full = 1; strobe(last_bit_rx);
        chk("R10", reg_rdata, 2); chk("R10", pulse_cnt, 2);

        // R7: set between read and write keeps flag
        cur_req = "R7";
        rd(); strobe(last_bit_rx); wr(2'b00);
        chk("R7", reg_rdata, 2);
        // R7: write of 0 in the same cycle as a set
        rd();
        reg_wdata = 2'b00; reg_wr = 1; last_bit_rx = 1; cyc(1);
        reg_wr = 0; last_bit_rx = 0; cyc(1);
        chk("R7", reg_rdata, 2);
        rd(); wr(2'b00); chk("R7", reg_rdata, 0);
        cyc(3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule